// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the first six octets of each received Ethernet frame, which carry the 48-bit destination address, and decides whether the frame is kept or dropped. The frame arrives one octet per cycle. A strobe marks the first octet, and a second strobe marks every cycle that carries a valid octet. Once the sixth address octet has been taken, the block registers a verdict: accept or reject, together with the reason. The verdict stays on the outputs until the next frame starts.

The verdict draws on four sources:

- a bank of exact-match entries, armed one at a time through a simple write port;
- a 64-bit table indexed by a 6-bit XOR fold of the destination, which applies to group addresses only;
- a broadcast path for the all-ones address;
- a copy-all flag that catches everything else.

The exact entries are written in two halves. Writing the low half disarms the entry, and writing the high half arms it again. As a result, an entry never matches while it holds a half-written address.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` is 0, every exact entry is disarmed with both words zero, both hash words are zero, the hash-enable flag is 1, and the copy-all and broadcast-disable flags are 0.
- R2: Write addresses are laid out as follows:
  - Entry i has its low word at address 2i and its high word at 2i+1.
  - The hash low word is at 16, the hash high word at 17, and the flags word at 18.
  - Flags bit 0 is copy-all, bit 1 is hash-enable and bit 2 is broadcast-disable.
  - The low word holds octet 0 in bits 7:0 up to octet 3 in bits 31:24.
  - The high word holds octet 4 in bits 7:0 and octet 5 in bits 15:8.
- R3: A destination that equals an armed entry is accepted with `dec_kind` 1 (exact). The kind codes are 0 none, 1 exact, 2 hash, 3 broadcast and 4 copy-all.
- R4: Writing an entry's low word disarms that entry, so it matches nothing. Writing its high word re-arms it.
- R5: The hash index is 6 bits. Bit k of the destination stream is octet k/8, bit k mod 8, counting from octet 0 and least significant bit first. That bit is XORed into index bit k mod 6.
- R6: An index below 32 selects that bit of the hash low word. An index of 32 or more selects bit (index−32) of the hash high word. A set bit accepts the frame with kind 2.
- R7: The hash lookup applies only when octet 0 bit 0 of the destination is 1 (a group address).
- R8: With hash-enable clear, a hash hit never accepts a frame.
- R9: The all-ones destination is accepted with kind 3 unless broadcast-disable is set. When broadcast-disable is set and copy-all is clear, that destination is rejected. Exact entries and the hash table never apply to this destination.
- R10: With copy-all set, a frame that no other rule accepts is accepted with kind 4. This includes a broadcast frame while broadcast-disable is set.
- R11: When a destination hits both an exact entry and the hash table, kind 1 wins.
- R12: Only cycles with `rx_valid` high carry octets. An octet with `rx_sof` high is octet 0. `dec_valid` rises exactly one clock after the sixth octet is taken.
- R13: The verdict stays unchanged until an octet with `rx_sof` arrives. That octet clears `dec_valid` at the same edge and starts a new address, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Marks octet 0 of a frame (qualified by rx_valid) |
| rx_valid | input | 1 | rx_byte carries an octet this cycle |
| rx_byte | input | 8 | Received octet |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 5 | Register write address (R2) |
| cfg_wr_data | input | 32 | Register write data |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 3 | Reason code (R3) |

## Verification
The internal state of this block shows at the ports only through the verdict of the next frame. The affected state is the armed bits, the stored words, the table, the flags and the octet counter.

A stuck or wrongly cleared armed bit, or a wrongly ordered octet in a stored word, changes the verdict or kind of the first frame addressed to that entry. A wrong fold bit or wrong table half changes the verdict of the first group frame whose index lands there.

A counter error moves the rising edge of `dec_valid` away from the cycle after the sixth octet. The bench compares the outputs against its model on every clock, so such an error shows up at once.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

   localparam int unsigned DA_OCTETS = 6;
   localparam int unsigned DA_BITS   = DA_OCTETS * 8;
   localparam int unsigned HIDX_BITS = 6;
   localparam int unsigned HTBL_BITS = 1 << HIDX_BITS;

   typedef enum logic [2:0] {
      KIND_NONE    = 3'd0,
      KIND_EXACT   = 3'd1,
      KIND_HASH    = 3'd2,
      KIND_BCAST   = 3'd3,
      KIND_PROMISC = 3'd4
   } match_kind_e;

   typedef struct packed {
      logic copy_all;
      logic hash_en;
      logic bcast_dis;
   } filt_flags_t;

endpackage

// File: rtl/rx_addr_hash.sv
// XOR fold of the destination address into a table index.
module rx_addr_hash #(
   parameter int unsigned AW = 48,
   parameter int unsigned IW = 6
) (
   input  logic [AW-1:0] dest,
   output logic [IW-1:0] idx
);

   function automatic logic [AW-1:0] lane_mask(int unsigned lane);
      logic [AW-1:0] m;
      m = '0;
      for (int unsigned k = 0; k < AW; k++) begin
         if ((k % IW) == lane) m[k] = 1'b1;
      end
      return m;
   endfunction

   for (genvar p = 0; p < IW; p++) begin : g_lane
      localparam logic [AW-1:0] MASK = lane_mask(p);
      assign idx[p] = ^(dest & MASK);
   end

endmodule

// File: rtl/rx_addr_exact.sv
// Bank of exact-match entries with disarm-on-low / arm-on-high writes.
module rx_addr_exact #(
   parameter int unsigned N  = 8,
   parameter int unsigned EW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_hi,
   input  logic [EW-1:0] wr_entry,
   input  logic [31:0]   wr_data,
   input  logic [47:0]   dest,
   output logic          hit
);

   logic [N-1:0] match;

   for (genvar g = 0; g < N; g++) begin : g_ent
      logic [31:0] lo_q;
      logic [15:0] hi_q;
      logic        armed_q;
      logic        sel;

      assign sel = wr_en && (wr_entry == EW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            armed_q <= 1'b0;
         end else if (sel) begin
            if (wr_hi) begin
               hi_q    <= wr_data[15:0];
               armed_q <= 1'b1;
            end else begin
               lo_q    <= wr_data;
               armed_q <= 1'b0;
            end
         end
      end

      assign match[g] = armed_q && (dest == {hi_q, lo_q});

      // R4: a low-word write leaves the entry unable to match
      p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && !wr_hi) |=> !armed_q);
      // R4: a high-word write arms the entry
      p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && wr_hi) |=> armed_q);
   end

   assign hit = |match;

endmodule

// File: rtl/rx_addr_cfg.sv
// Hash table words, filter flags and table lookup.
module rx_addr_cfg
   import rx_addr_filter_pkg::*;
#(
   parameter int unsigned IW = HIDX_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hlo,
   input  logic          wr_hhi,
   input  logic          wr_flg,
   input  logic [31:0]   wr_data,
   input  logic [IW-1:0] idx,
   output logic          tbl_bit,
   output filt_flags_t   flags
);

   localparam int unsigned TBL = 1 << IW;

   logic [31:0] hlo_q, hhi_q;
   logic [TBL-1:0] tbl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hlo_q <= '0;
         hhi_q <= '0;
         flags <= '{copy_all: 1'b0, hash_en: 1'b1, bcast_dis: 1'b0};
      end else begin
         if (wr_hlo) hlo_q <= wr_data;
         if (wr_hhi) hhi_q <= wr_data;
         if (wr_flg) begin
            flags.copy_all  <= wr_data[0];
            flags.hash_en   <= wr_data[1];
            flags.bcast_dis <= wr_data[2];
         end
      end
   end

   assign tbl     = {hhi_q, hlo_q};
   assign tbl_bit = tbl[idx];

   // R1/R2: a flags write lands exactly as written
   p_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flg |=> (flags.hash_en == $past(wr_data[1])));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rx_addr_filter_pkg::*;
#(
   parameter int unsigned NUM_EXACT = 8,
   localparam int unsigned CFG_AW = $clog2(2 * NUM_EXACT + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_sof,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              cfg_wr_en,
   input  logic [CFG_AW-1:0] cfg_wr_addr,
   input  logic [31:0]       cfg_wr_data,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [2:0]        dec_kind
);

   localparam int unsigned EW        = $clog2(NUM_EXACT);
   localparam int unsigned ENT_WORDS = 2 * NUM_EXACT;
   localparam int unsigned A_HLO     = ENT_WORDS;
   localparam int unsigned A_HHI     = ENT_WORDS + 1;
   localparam int unsigned A_FLG     = ENT_WORDS + 2;
   localparam int unsigned CW        = $clog2(DA_OCTETS + 1);

   if (NUM_EXACT < 2 || NUM_EXACT > 32) begin : g_bad_n
      $error("rx_addr_filter: NUM_EXACT out of range");
   end
   if (CFG_AW < EW + 1) begin : g_bad_aw
      $error("rx_addr_filter: address width too small");
   end

   // write decode
   logic          wr_ent, wr_hlo, wr_hhi, wr_flg;
   logic [EW-1:0] wr_idx;

   assign wr_ent = cfg_wr_en && (cfg_wr_addr < CFG_AW'(ENT_WORDS));
   assign wr_hlo = cfg_wr_en && (cfg_wr_addr == CFG_AW'(A_HLO));
   assign wr_hhi = cfg_wr_en && (cfg_wr_addr == CFG_AW'(A_HHI));
   assign wr_flg = cfg_wr_en && (cfg_wr_addr == CFG_AW'(A_FLG));
   assign wr_idx = cfg_wr_addr[EW:1];

   // octet collector
   logic [CW-1:0]         cnt_q;
   logic [DA_BITS-9:0]    addr_q;
   logic [DA_BITS-1:0]    dest;
   logic                  take_last;

   assign take_last = rx_valid && !rx_sof && (cnt_q == CW'(DA_OCTETS - 1));
   assign dest      = {rx_byte, addr_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
      end else if (rx_valid) begin
         if (rx_sof) begin
            addr_q[7:0] <= rx_byte;
            cnt_q       <= CW'(1);
         end else if (cnt_q != '0 && cnt_q < CW'(DA_OCTETS - 1)) begin
            addr_q[cnt_q*8 +: 8] <= rx_byte;
            cnt_q                <= cnt_q + CW'(1);
         end else if (take_last) begin
            cnt_q <= CW'(DA_OCTETS);
         end
      end
   end

   // lookups
   logic [HIDX_BITS-1:0] hidx;
   logic                 exact_hit, tbl_bit;
   filt_flags_t          flags;

   rx_addr_hash #(.AW(DA_BITS), .IW(HIDX_BITS)) u_hash (
      .dest (dest),
      .idx  (hidx)
   );

   rx_addr_exact #(.N(NUM_EXACT), .EW(EW)) u_exact (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ent),
      .wr_hi    (cfg_wr_addr[0]),
      .wr_entry (wr_idx),
      .wr_data  (cfg_wr_data),
      .dest     (dest),
      .hit      (exact_hit)
   );

   rx_addr_cfg #(.IW(HIDX_BITS)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hlo  (wr_hlo),
      .wr_hhi  (wr_hhi),
      .wr_flg  (wr_flg),
      .wr_data (cfg_wr_data),
      .idx     (hidx),
      .tbl_bit (tbl_bit),
      .flags   (flags)
   );

   // verdict
   logic        is_bcast, hash_ok;
   match_kind_e kind_d;

   assign is_bcast = &dest;
   assign hash_ok  = dest[0] && flags.hash_en && tbl_bit;

   always_comb begin
      if (is_bcast) begin
         if (!flags.bcast_dis)   kind_d = KIND_BCAST;
         else if (flags.copy_all) kind_d = KIND_PROMISC;
         else                     kind_d = KIND_NONE;
      end else if (exact_hit)     kind_d = KIND_EXACT;
      else if (hash_ok)           kind_d = KIND_HASH;
      else if (flags.copy_all)    kind_d = KIND_PROMISC;
      else                        kind_d = KIND_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_kind   <= KIND_NONE;
      end else if (rx_valid && rx_sof) begin
         dec_valid <= 1'b0;
      end else if (take_last) begin
         dec_valid  <= 1'b1;
         dec_accept <= (kind_d != KIND_NONE);
         dec_kind   <= kind_d;
      end
   end

   // R12: the verdict appears only after the sixth octet was taken
   p_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> $past(take_last));
   // R13: a start octet clears the verdict at that edge
   p_sof_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_sof) |=> !dec_valid);
   // R13: the verdict holds until the next start octet
   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !(rx_valid && rx_sof)) |=>
         (dec_valid && $stable(dec_accept) && $stable(dec_kind)));
   // R3: accept and reason agree
   p_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_accept == (dec_kind != KIND_NONE)));

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_sof = 1'b0, rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        cfg_wr_en = 1'b0;
   logic [4:0]  cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        dec_valid, dec_accept;
   logic [2:0]  dec_kind;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_addr_filter uut (
      .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .dec_valid(dec_valid),
      .dec_accept(dec_accept), .dec_kind(dec_kind)
   );

   int    n_cmp = 0, n_bad = 0;
   bit    finished = 0;
   string cur_req = "R1";

   // reference model state
   logic [31:0] m_lo [8];
   logic [15:0] m_hi [8];
   bit          m_arm [8];
   logic [31:0] m_hlo, m_hhi;
   bit          m_copy, m_hen, m_bdis;
   logic [47:0] m_addr;
   int          m_cnt;
   bit          m_valid, m_acc;
   int          m_kind;

   function automatic int fold(logic [47:0] a);
      int r = 0;
      for (int k = 0; k < 48; k++) if (a[k]) r = r ^ (1 << (k % 6));
      return r;
   endfunction

   task automatic decide(logic [47:0] d);
      int  h;
      bit  tb;
      bit  ex = 0;
      h  = fold(d);
      tb = (h < 32) ? m_hlo[h] : m_hhi[h-32];
      for (int i = 0; i < 8; i++) if (m_arm[i] && d == {m_hi[i], m_lo[i]}) ex = 1;
      if (d == '1) begin
         if (!m_bdis)     m_kind = 3;
         else if (m_copy) m_kind = 4;
         else             m_kind = 0;
      end else if (ex)                   m_kind = 1;
      else if (d[0] && m_hen && tb)      m_kind = 2;
      else if (m_copy)                   m_kind = 4;
      else                               m_kind = 0;
      m_acc = (m_kind != 0);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_arm[i] = 0; end
         m_hlo = 0; m_hhi = 0; m_copy = 0; m_hen = 1; m_bdis = 0;
         m_addr = 0; m_cnt = 0; m_valid = 0; m_acc = 0; m_kind = 0;
      end else begin
         if (rx_valid) begin
            if (rx_sof) begin
               m_addr = 0; m_addr[7:0] = rx_byte; m_cnt = 1; m_valid = 0;
            end else if (m_cnt >= 1 && m_cnt <= 4) begin
               m_addr[m_cnt*8 +: 8] = rx_byte; m_cnt++;
            end else if (m_cnt == 5) begin
               m_addr[47:40] = rx_byte; m_cnt = 6;
               decide(m_addr); m_valid = 1;
            end
         end
         if (cfg_wr_en) begin
            if (cfg_wr_addr < 16) begin
               if (cfg_wr_addr[0]) begin
                  m_hi[cfg_wr_addr>>1] = cfg_wr_data[15:0]; m_arm[cfg_wr_addr>>1] = 1;
               end else begin
                  m_lo[cfg_wr_addr>>1] = cfg_wr_data; m_arm[cfg_wr_addr>>1] = 0;
               end
            end else if (cfg_wr_addr == 16) m_hlo = cfg_wr_data;
            else if (cfg_wr_addr == 17) m_hhi = cfg_wr_data;
            else if (cfg_wr_addr == 18) begin
               m_copy = cfg_wr_data[0]; m_hen = cfg_wr_data[1]; m_bdis = cfg_wr_data[2];
            end
         end
      end
   end

   // every-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         n_cmp++;
         if (dec_valid !== m_valid ||
             (m_valid && (dec_accept !== m_acc || dec_kind !== 3'(m_kind)))) begin
            n_bad++;
            $display("FAIL %s: valid/accept/kind got %b/%b/%0d expected %b/%b/%0d at %0t",
                     cur_req, dec_valid, dec_accept, dec_kind, m_valid, m_acc, m_kind, $time);
         end
      end
   end

   task automatic wr(int a, logic [31:0] d);
      cfg_wr_en = 1; cfg_wr_addr = 5'(a); cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 0;
   endtask

   task automatic prog(int i, logic [47:0] a);
      wr(2*i, a[31:0]);
      wr(2*i+1, {16'h0, a[47:32]});
   endtask

   task automatic idle(int n);
      rx_valid = 0; rx_sof = 0;
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(logic [47:0] a, int gap);
      for (int i = 0; i < 6; i++) begin
         rx_valid = 1; rx_sof = (i == 0); rx_byte = a[i*8 +: 8];
         @(negedge clk);
         if (gap > 0) idle(gap);
      end
      for (int i = 0; i < 3; i++) begin
         rx_valid = 1; rx_sof = 0; rx_byte = 8'(8'hA0 + i);
         @(negedge clk);
      end
      idle(2);
   endtask

   // direct check that names its requirement
   task automatic expect_out(string req, bit v, bit acc, int kind);
      n_cmp++;
      if (dec_valid !== v || (v && (dec_accept !== acc || dec_kind !== 3'(kind)))) begin
         n_bad++;
         $display("FAIL %s: got %b/%b/%0d expected %b/%b/%0d",
                  req, dec_valid, dec_accept, dec_kind, v, acc, kind);
      end
   endtask

   function automatic logic [47:0] find_group(bit want_high);
      logic [47:0] a = 48'h0000_0000_5501;
      for (int s = 0; s < 256; s++) begin
         a[47:40] = 8'(s);
         if ((fold(a) >= 32) == want_high) return a;
      end
      return a;
   endfunction

   task automatic set_hash_bit(logic [47:0] a, inout logic [31:0] lo, inout logic [31:0] hi);
      int h = fold(a);
      if (h < 32) lo[h] = 1'b1; else hi[h-32] = 1'b1;
      wr(16, lo); wr(17, hi);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] ua, ub, gl, gh, gx;
      logic [31:0] hl, hh;
      hl = 0; hh = 0;
      ua = 48'h6655_4433_2210;
      ub = 48'h1234_5678_9A02;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      cur_req = "R1";
      expect_out("R1", 0, 0, 0);
      frame(48'h0, 0);
      expect_out("R1", 1, 0, 0);
      frame(48'h0000_0000_0001, 0);
      expect_out("R1", 1, 0, 0);

      cur_req = "R3";
      prog(3, ua);
      frame(ua, 0);
      expect_out("R3", 1, 1, 1);
      frame(ub, 1);
      expect_out("R3", 1, 0, 0);

      cur_req = "R4";
      wr(6, ub[31:0]);
      frame(ua, 0);
      expect_out("R4", 1, 0, 0);
      frame(ub, 0);
      expect_out("R4", 1, 0, 0);
      wr(7, {16'h0, ub[47:32]});
      frame(ub, 0);
      expect_out("R4", 1, 1, 1);
      prog(7, ua);
      frame(ua, 2);
      expect_out("R2", 1, 1, 1);

      cur_req = "R6";
      gl = find_group(0);
      gh = find_group(1);
      set_hash_bit(gl, hl, hh);
      frame(gl, 0);
      expect_out("R5", 1, 1, 2);
      frame(gh, 0);
      expect_out("R6", 1, 0, 0);
      set_hash_bit(gh, hl, hh);
      frame(gh, 0);
      expect_out("R6", 1, 1, 2);

      cur_req = "R7";
      wr(16, '1); wr(17, '1);
      frame(ua ^ 48'h0000_0000_0100, 0);
      expect_out("R7", 1, 0, 0);
      gx = 48'h0102_0304_0507;
      frame(gx, 0);
      expect_out("R7", 1, 1, 2);

      cur_req = "R11";
      prog(1, gx);
      frame(gx, 0);
      expect_out("R11", 1, 1, 1);

      cur_req = "R8";
      wr(18, 32'h0);
      frame(gh, 0);
      expect_out("R8", 1, 0, 0);

      cur_req = "R9";
      frame('1, 0);
      expect_out("R9", 1, 1, 3);
      wr(18, 32'h4);
      frame('1, 1);
      expect_out("R9", 1, 0, 0);

      cur_req = "R10";
      wr(18, 32'h5);
      frame('1, 0);
      expect_out("R10", 1, 1, 4);
      frame(48'hDEAD_BEEF_0010, 0);
      expect_out("R10", 1, 1, 4);
      frame(ua, 0);
      expect_out("R10", 1, 1, 1);
      wr(18, 32'h2);

      cur_req = "R12";
      rx_valid = 1; rx_sof = 1; rx_byte = ua[7:0];
      @(negedge clk);
      for (int i = 1; i < 5; i++) begin
         rx_sof = 0; rx_byte = ua[i*8 +: 8];
         @(negedge clk);
         idle(1);
         rx_valid = 1;
      end
      rx_sof = 0; rx_byte = ua[47:40];
      @(negedge clk);
      expect_out("R12", 1, 1, 1);
      idle(3);

      cur_req = "R13";
      rx_valid = 1; rx_sof = 1; rx_byte = 8'h11;
      @(negedge clk);
      expect_out("R13", 0, 0, 0);
      rx_sof = 0; rx_byte = 8'h22;
      @(negedge clk);
      frame(ub, 0);
      expect_out("R13", 1, 1, 1);
      repeat (5) begin rx_valid = 1; rx_sof = 0; rx_byte = '1; @(negedge clk); end
      expect_out("R13", 1, 1, 1);
      idle(2);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule